// File: doc/BRIEF.md
# Register-Launched Two-Dimensional DMA Frontend

This block is the software-facing front of a two-dimensional DMA engine. A processor reaches it through a simple 32-bit register bus. The bus has a byte address, write and read enables, write data, read data and a ready signal. Through this bus the processor stages a configuration word and six 64-bit descriptor fields: source address, destination address, byte length, source stride, destination stride and repetition count. Each 64-bit field is written as two 32-bit halves.

A transfer starts with a read, not a write. Reading the launch register of a stream first checks the staged setup. If the setup is valid, the block offers the descriptor to the backend on a valid/ready handshake. The bus read completes in the cycle the backend accepts, and it returns a fresh, nonzero transfer ID for that stream. If the setup is invalid, the read completes at once with 0 and nothing is launched.

The backend sends a completion pulse with a stream index and an ID. The frontend uses it to keep two things per stream: the number of transfers still outstanding, and the ID of the last transfer that finished. Software can read both.

Top module: `dma2d_regfront`

## Requirements
- R1: After reset, the configuration word, all twelve descriptor words, every status register and every done register read 0.
- R2: The configuration word sits at offset 0x00. Bits 16:0 are writable and read back as written: bit 0 decouples read from write-address, bit 1 decouples read from write, bits 3:2 enable burst-length reduction for destination and source, bits 9:4 hold two 3-bit log2 maximum burst lengths, bit 10 selects 2D mode, and bits 16:11 hold two 3-bit protocol selects. Bits 31:17 always read 0.
- R3: The descriptor words occupy 0xD0 to 0xFC, with the low half of each field at the lower address. The pairs are: destination address at 0xD0/0xD4, source address at 0xD8/0xDC, length at 0xE0/0xE4, destination stride at 0xE8/0xEC, source stride at 0xF0/0xF4 and repetition count at 0xF8/0xFC. These words read back as written and drive the descriptor outputs as 64-bit values.
- R4: A setup is rejected when the length is 0, or when bit 10 of the configuration word is set and the repetition count is 0. A launch read of a rejected setup returns 0 in the same cycle, never asserts `desc_valid`, and leaves the stream's busy count unchanged.
- R5: A launch read of a valid setup on stream k (offset 0x44 + 4k) drives `desc_valid` with `desc_stream` = k. It holds `bus_ready` low until `desc_ready` is high. The ID is returned in that acceptance cycle.
- R6: Transfer IDs are counted separately for each stream. The first accepted launch after reset returns 1, and each later one returns the previous ID plus 1.
- R7: When an ID counter wraps, it skips 0, so the ID after the all-ones value is 1.
- R8: The status register of stream k (offset 0x04 + 4k) reports in bits 9:0 the number of accepted launches minus the number of counted completions. Bits 31:10 read 0.
- R9: A completion pulse for stream k with ID v sets the done register of stream k (offset 0x84 + 4k) to v and lowers its busy count by 1. A completion pulse on a stream with nothing outstanding is ignored.
- R10: Writes to status, launch, done or unmapped offsets change nothing. Reads of unmapped offsets (for example 0xC4 to 0xCC) return 0.
- R11: Every access other than a launch read of a valid setup completes with `bus_ready` high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write request, held until ready |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read request, held until ready |
| bus_rd_data | output | 32 | Read data, valid while bus_rd_en and bus_ready are high |
| bus_ready | output | 1 | Access completes on this clock edge |
| desc_valid | output | 1 | Descriptor offered to the backend |
| desc_ready | input | 1 | Backend accepts the descriptor |
| desc_stream | output | STREAM_W | Stream of the offered descriptor |
| desc_id | output | ID_W | Transfer ID of the offered descriptor |
| desc_cfg | output | 32 | Configuration word |
| desc_src | output | 64 | Source address |
| desc_dst | output | 64 | Destination address |
| desc_len | output | 64 | Length in bytes |
| desc_src_stride | output | 64 | Source stride |
| desc_dst_stride | output | 64 | Destination stride |
| desc_reps | output | 64 | Repetition count |
| cpl_valid | input | 1 | Completion pulse |
| cpl_stream | input | STREAM_W | Stream of the completion |
| cpl_id | input | ID_W | ID of the completed transfer |

## Verification
Read data, `bus_ready` and the descriptor handshake are combinational from the request, so the bench samples them in the same cycle the request is driven, 4 ns after the falling edge and before the rising edge that ends the access. State changes (staged words, ID counters, busy counts and done IDs) take effect at the rising edge of a write, an acceptance or a completion pulse. The bench therefore checks them with a separate read that starts at the next falling edge, one cycle later. The stall case holds `desc_ready` low for three cycles and checks in each of them that `bus_ready` is low while `desc_valid` is high. It then raises `desc_ready` and checks that the ID comes back in that same cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    localparam int WORD_W        = 32;
    localparam int REG_AW        = 8;
    localparam int MAX_STREAMS   = 16;
    localparam int DESC_WORDS    = 12;
    localparam int CFG_BITS      = 17;
    localparam int MULTI_DIM_BIT = 10;

    localparam logic [REG_AW-1:0] OFS_CFG    = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STATUS = 8'h04;
    localparam logic [REG_AW-1:0] OFS_LAUNCH = 8'h44;
    localparam logic [REG_AW-1:0] OFS_DONE   = 8'h84;
    localparam logic [REG_AW-1:0] OFS_GAP    = 8'hC4;
    localparam logic [REG_AW-1:0] OFS_DESC   = 8'hD0;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CFG,
        RG_STATUS,
        RG_LAUNCH,
        RG_DONE,
        RG_DESC
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [3:0]  idx;
    } decode_t;

    typedef struct packed {
        logic [63:0] dst;
        logic [63:0] src;
        logic [63:0] len;
        logic [63:0] dst_stride;
        logic [63:0] src_stride;
        logic [63:0] reps;
    } desc_t;

    function automatic decode_t decode_addr(input logic [REG_AW-1:0] a);
        decode_t     d;
        logic [7:0]  off;
        d.region = RG_NONE;
        d.idx    = '0;
        off      = '0;
        if (a[1:0] == 2'b00) begin
            if (a == OFS_CFG) begin
                d.region = RG_CFG;
            end else if (a < OFS_LAUNCH) begin
                off      = a - OFS_STATUS;
                d.region = RG_STATUS;
                d.idx    = off[5:2];
            end else if (a < OFS_DONE) begin
                off      = a - OFS_LAUNCH;
                d.region = RG_LAUNCH;
                d.idx    = off[5:2];
            end else if (a < OFS_GAP) begin
                off      = a - OFS_DONE;
                d.region = RG_DONE;
                d.idx    = off[5:2];
            end else if (a >= OFS_DESC) begin
                off      = a - OFS_DESC;
                d.region = RG_DESC;
                d.idx    = off[5:2];
            end
        end
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_mask();
        return WORD_W'((64'd1 << CFG_BITS) - 64'd1);
    endfunction

endpackage

// File: rtl/dma2d_staging.sv
module dma2d_staging
    import dma2d_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  decode_t             dec,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   cfg_q,
    output desc_t               desc,
    output logic [WORD_W-1:0]   desc_word,
    output logic                setup_ok
);

    localparam int FIELDS = DESC_WORDS / 2;

    logic [WORD_W-1:0] words_q [DESC_WORDS];
    logic [63:0]       field   [FIELDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en && dec.region == RG_CFG) begin
            cfg_q <= wr_data & cfg_mask();
        end
    end

    for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[w] <= '0;
            end else if (wr_en && dec.region == RG_DESC && 32'(dec.idx) == w) begin
                words_q[w] <= wr_data;
            end
        end
    end

    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        assign field[f] = {words_q[2*f+1], words_q[2*f]};
    end

    always_comb begin
        desc.dst        = field[0];
        desc.src        = field[1];
        desc.len        = field[2];
        desc.dst_stride = field[3];
        desc.src_stride = field[4];
        desc.reps       = field[5];
    end

    always_comb begin
        desc_word = '0;
        if (32'(dec.idx) < DESC_WORDS) begin
            desc_word = words_q[dec.idx];
        end
    end

    always_comb begin
        setup_ok = (desc.len != '0);
        if (cfg_q[MULTI_DIM_BIT] && desc.reps == '0) begin
            setup_ok = 1'b0;
        end
    end

    assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q & ~cfg_mask()) == '0);

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.region == RG_CFG) |=> cfg_q[CFG_BITS-1:0] == $past(wr_data[CFG_BITS-1:0]));

endmodule

// File: rtl/dma2d_stream_ctx.sv
module dma2d_stream_ctx #(
    parameter int ID_W   = 32,
    parameter int BUSY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              cpl_hit,
    input  logic [ID_W-1:0]   cpl_id,
    output logic [ID_W-1:0]   next_id,
    output logic [ID_W-1:0]   done_id,
    output logic [BUSY_W-1:0] outstanding
);

    logic              cpl_take;
    logic [ID_W-1:0]   id_inc;

    assign cpl_take = cpl_hit && (outstanding != '0);

    always_comb begin
        id_inc = next_id + ID_W'(1);
        if (id_inc == '0) begin
            id_inc = ID_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_id <= ID_W'(1);
        end else if (accept) begin
            next_id <= id_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_id <= '0;
        end else if (cpl_take) begin
            done_id <= cpl_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= '0;
        end else if (accept && !cpl_take) begin
            outstanding <= outstanding + BUSY_W'(1);
        end else if (!accept && cpl_take) begin
            outstanding <= outstanding - BUSY_W'(1);
        end
    end

    assert_id_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        next_id != '0);

    assert_busy_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && !cpl_hit) |=> outstanding == $past(outstanding) + BUSY_W'(1));

    assert_cpl_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (cpl_hit && outstanding == '0 && !accept) |=> (outstanding == '0 && $stable(done_id)));

endmodule

// File: rtl/dma2d_regfront.sv
module dma2d_regfront
    import dma2d_pkg::*;
#(
    parameter int NUM_STREAMS = 16,
    parameter int ID_W        = 32,
    parameter int BUSY_W      = 10,
    localparam int STREAM_W   = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr_en,
    input  logic [31:0]          bus_wr_data,
    input  logic                 bus_rd_en,
    output logic [31:0]          bus_rd_data,
    output logic                 bus_ready,
    output logic                 desc_valid,
    input  logic                 desc_ready,
    output logic [STREAM_W-1:0]  desc_stream,
    output logic [ID_W-1:0]      desc_id,
    output logic [31:0]          desc_cfg,
    output logic [63:0]          desc_src,
    output logic [63:0]          desc_dst,
    output logic [63:0]          desc_len,
    output logic [63:0]          desc_src_stride,
    output logic [63:0]          desc_dst_stride,
    output logic [63:0]          desc_reps,
    input  logic                 cpl_valid,
    input  logic [STREAM_W-1:0]  cpl_stream,
    input  logic [ID_W-1:0]      cpl_id
);

    decode_t            dec;
    logic               idx_ok;
    logic [STREAM_W-1:0] sidx;
    logic               launch_req;
    logic               accept;
    logic               setup_ok;
    logic [WORD_W-1:0]  cfg_q;
    logic [WORD_W-1:0]  desc_word;
    desc_t              staged;

    logic [ID_W-1:0]    next_ids [NUM_STREAMS];
    logic [ID_W-1:0]    done_ids [NUM_STREAMS];
    logic [BUSY_W-1:0]  busy     [NUM_STREAMS];

    assign dec        = decode_addr(bus_addr);
    assign sidx       = dec.idx[STREAM_W-1:0];
    assign idx_ok     = 32'(dec.idx) < NUM_STREAMS;
    assign launch_req = bus_rd_en && dec.region == RG_LAUNCH && idx_ok;
    assign desc_valid = launch_req && setup_ok;
    assign accept     = desc_valid && desc_ready;
    assign bus_ready  = !desc_valid || desc_ready;

    dma2d_staging u_staging (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr_en),
        .dec       (dec),
        .wr_data   (bus_wr_data),
        .cfg_q     (cfg_q),
        .desc      (staged),
        .desc_word (desc_word),
        .setup_ok  (setup_ok)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        dma2d_stream_ctx #(
            .ID_W   (ID_W),
            .BUSY_W (BUSY_W)
        ) u_ctx (
            .clk         (clk),
            .rst         (rst),
            .accept      (accept && 32'(sidx) == s),
            .cpl_hit     (cpl_valid && 32'(cpl_stream) == s),
            .cpl_id      (cpl_id),
            .next_id     (next_ids[s]),
            .done_id     (done_ids[s]),
            .outstanding (busy[s])
        );
    end

    assign desc_stream     = sidx;
    assign desc_id         = next_ids[sidx];
    assign desc_cfg        = cfg_q;
    assign desc_src        = staged.src;
    assign desc_dst        = staged.dst;
    assign desc_len        = staged.len;
    assign desc_src_stride = staged.src_stride;
    assign desc_dst_stride = staged.dst_stride;
    assign desc_reps       = staged.reps;

    always_comb begin
        bus_rd_data = '0;
        if (bus_rd_en) begin
            unique case (dec.region)
                RG_CFG:    bus_rd_data = cfg_q;
                RG_STATUS: if (idx_ok) bus_rd_data = 32'(busy[sidx]);
                RG_LAUNCH: if (desc_valid) bus_rd_data = 32'(next_ids[sidx]);
                RG_DONE:   if (idx_ok) bus_rd_data = 32'(done_ids[sidx]);
                RG_DESC:   bus_rd_data = desc_word;
                default:   bus_rd_data = '0;
            endcase
        end
    end

    assert_launch_gated_R4: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (staged.len != '0 && !(cfg_q[MULTI_DIM_BIT] && staged.reps == '0)));

    assert_reject_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (launch_req && !setup_ok) |-> (bus_ready && bus_rd_data == '0 && !desc_valid));

    assert_stall_until_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !desc_ready) |-> !bus_ready);

    assert_id_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
        accept |-> (bus_rd_data != '0 && bus_rd_data == 32'(desc_id)));

    assert_plain_ready_R11: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr_en || bus_rd_en) && dec.region != RG_LAUNCH) |-> bus_ready);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && dec.region == RG_NONE) |-> bus_rd_data == '0);

endmodule

// File: tb/sim_dma2d_regfront.sv
module sim_dma2d_regfront;

    localparam int TB_ID_W = 4;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Rows: writes stage values, reads compare against exp (req = requirement number)
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000, 8'd2},   // R2 full write
        '{1'b0, 8'h00, 32'h0,         32'h0001_FFFF, 8'd2},   // R2 reserved bits read 0
        '{1'b1, 8'hD0, 32'h1111_0000, 32'h0,         8'd3},   // R3
        '{1'b1, 8'hD4, 32'h2222_0000, 32'h0,         8'd3},
        '{1'b1, 8'hF4, 32'h5A5A_A5A5, 32'h0,         8'd3},
        '{1'b0, 8'hD0, 32'h0,         32'h1111_0000, 8'd3},   // R3 low half
        '{1'b0, 8'hD4, 32'h0,         32'h2222_0000, 8'd3},   // R3 high half
        '{1'b0, 8'hF4, 32'h0,         32'h5A5A_A5A5, 8'd3},
        '{1'b1, 8'h04, 32'hDEAD_BEEF, 32'h0,         8'd10},  // R10 write to status
        '{1'b0, 8'h04, 32'h0,         32'h0000_0000, 8'd10},
        '{1'b0, 8'hC4, 32'h0,         32'h0000_0000, 8'd10},  // R10 unmapped gap
        '{1'b1, 8'hC8, 32'h1234_5678, 32'h0,         8'd10},
        '{1'b0, 8'hC8, 32'h0,         32'h0000_0000, 8'd10},
        '{1'b1, 8'h00, 32'h0000_0000, 32'h0,         8'd2}
    };

    logic                clk = 1'b0;
    logic                rst;
    logic [7:0]          bus_addr;
    logic                bus_wr_en;
    logic [31:0]         bus_wr_data;
    logic                bus_rd_en;
    logic [31:0]         bus_rd_data;
    logic                bus_ready;
    logic                desc_valid;
    logic                desc_ready;
    logic [3:0]          desc_stream;
    logic [TB_ID_W-1:0]  desc_id;
    logic [31:0]         desc_cfg;
    logic [63:0]         desc_src, desc_dst, desc_len;
    logic [63:0]         desc_src_stride, desc_dst_stride, desc_reps;
    logic                cpl_valid;
    logic [3:0]          cpl_stream;
    logic [TB_ID_W-1:0]  cpl_id;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] r_data;
    int          r_waits;
    logic        r_valid;
    logic [63:0] r_len, r_src;
    logic [3:0]  r_stream;

    always #5 clk = ~clk;

    dma2d_regfront #(
        .NUM_STREAMS (16),
        .ID_W        (TB_ID_W),
        .BUSY_W      (10)
    ) u0 (
        .clk             (clk),
        .rst             (rst),
        .bus_addr        (bus_addr),
        .bus_wr_en       (bus_wr_en),
        .bus_wr_data     (bus_wr_data),
        .bus_rd_en       (bus_rd_en),
        .bus_rd_data     (bus_rd_data),
        .bus_ready       (bus_ready),
        .desc_valid      (desc_valid),
        .desc_ready      (desc_ready),
        .desc_stream     (desc_stream),
        .desc_id         (desc_id),
        .desc_cfg        (desc_cfg),
        .desc_src        (desc_src),
        .desc_dst        (desc_dst),
        .desc_len        (desc_len),
        .desc_src_stride (desc_src_stride),
        .desc_dst_stride (desc_dst_stride),
        .desc_reps       (desc_reps),
        .cpl_valid       (cpl_valid),
        .cpl_stream      (cpl_stream),
        .cpl_id          (cpl_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr    = a;
        bus_wr_data = d;
        bus_wr_en   = 1'b1;
        @(posedge clk);
        #1;
        bus_wr_en   = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        bus_addr  = a;
        bus_rd_en = 1'b1;
        r_waits   = 0;
        #4;
        while (!bus_ready) begin
            r_waits++;
            @(negedge clk);
            #4;
        end
        r_data   = bus_rd_data;
        r_valid  = desc_valid;
        r_len    = desc_len;
        r_src    = desc_src;
        r_stream = desc_stream;
        @(posedge clk);
        #1;
        bus_rd_en = 1'b0;
    endtask

    task automatic pulse_cpl(input logic [3:0] s, input logic [TB_ID_W-1:0] v);
        @(negedge clk);
        cpl_stream = s;
        cpl_id     = v;
        cpl_valid  = 1'b1;
        @(negedge clk);
        cpl_valid  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        bus_addr    = '0;
        bus_wr_en   = 1'b0;
        bus_wr_data = '0;
        bus_rd_en   = 1'b0;
        desc_ready  = 1'b1;
        cpl_valid   = 1'b0;
        cpl_stream  = '0;
        cpl_id      = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        bus_read(8'h00); check("R1 cfg", r_data, 32'h0);
        bus_read(8'hD0); check("R1 dst lo", r_data, 32'h0);
        bus_read(8'hFC); check("R1 reps hi", r_data, 32'h0);
        bus_read(8'h04); check("R1 status0", r_data, 32'h0);
        bus_read(8'hC0); check("R1 done15", r_data, 32'h0);

        // Table walk: R2, R3, R10, each read also checks R11 zero wait
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].addr, VEC[i].data);
            end else begin
                bus_read(VEC[i].addr);
                check($sformatf("R%0d vec %0d", VEC[i].req, i), r_data, VEC[i].exp);
                check($sformatf("R11 vec %0d waits", i), 32'(r_waits), 32'h0);
            end
        end

        // R4 zero length rejected
        bus_write(8'hF4, 32'h0);
        bus_read(8'h44);
        check("R4 len0 id", r_data, 32'h0);
        check("R4 len0 no valid", 32'(r_valid), 32'h0);
        check("R11 reject waits", 32'(r_waits), 32'h0);

        // Stage a valid 1D setup
        bus_write(8'hE0, 32'h0000_0040);
        bus_write(8'hD8, 32'h0000_1000);
        bus_write(8'hDC, 32'h0000_0002);
        bus_write(8'hD0, 32'h0000_8000);

        // R5 and R3 launch on stream 0
        bus_read(8'h44);
        check("R5 first id", r_data, 32'h1);
        check("R5 stream", 32'(r_stream), 32'h0);
        check("R3 len out", r_len[31:0], 32'h40);
        check("R3 src hi out", r_src[63:32], 32'h2);
        check("R3 src lo out", r_src[31:0], 32'h1000);

        // R6 per-stream sequence
        bus_read(8'h44); check("R6 stream0 second", r_data, 32'h2);
        bus_read(8'h48); check("R6 stream1 first", r_data, 32'h1);

        // R8 busy counts
        bus_read(8'h04); check("R8 status0", r_data, 32'h2);
        bus_read(8'h08); check("R8 status1", r_data, 32'h1);

        // R4 2D mode with zero repetitions
        bus_write(8'h00, 32'h0000_0400);
        bus_read(8'h44);
        check("R4 reps0 id", r_data, 32'h0);
        check("R4 reps0 no valid", 32'(r_valid), 32'h0);
        bus_read(8'h04); check("R4 busy unchanged", r_data, 32'h2);
        bus_write(8'hF8, 32'h3);
        bus_read(8'h44); check("R4 reps3 accepted", r_data, 32'h3);
        bus_write(8'h00, 32'h0);

        // R5 backpressure on stream 2
        @(negedge clk);
        bus_addr   = 8'h4C;
        bus_rd_en  = 1'b1;
        desc_ready = 1'b0;
        for (int c = 0; c < 3; c++) begin
            #4;
            check("R5 stall ready low", 32'(bus_ready), 32'h0);
            check("R5 stall valid high", 32'(desc_valid), 32'h1);
            @(negedge clk);
        end
        desc_ready = 1'b1;
        #4;
        check("R5 accept ready", 32'(bus_ready), 32'h1);
        check("R5 accept id", bus_rd_data, 32'h1);
        check("R5 accept stream", 32'(desc_stream), 32'h2);
        @(posedge clk);
        #1;
        bus_rd_en = 1'b0;

        // R9 completion on stream 0
        pulse_cpl(4'd0, 4'd3);
        bus_read(8'h84); check("R9 done0", r_data, 32'h3);
        bus_read(8'h04); check("R9 busy0 drop", r_data, 32'h2);

        // R9 completion with nothing outstanding is ignored
        pulse_cpl(4'd5, 4'd7);
        bus_read(8'h98); check("R9 done5 ignored", r_data, 32'h0);
        bus_read(8'h18); check("R9 busy5 stays", r_data, 32'h0);

        // R7 wrap on stream 3 with a 4-bit ID
        for (int k = 1; k <= 15; k++) begin
            bus_read(8'h50);
            check($sformatf("R6 stream3 id %0d", k), r_data, 32'(k));
        end
        bus_read(8'h50); check("R7 wrap skips zero", r_data, 32'h1);
        bus_read(8'h10); check("R8 status3 count", r_data, 32'h10);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule